// File: doc/BRIEF.md
# Strobe-Framed Serial Register Slave

This block is the device end of a three-wire serial control link that carries a separate active-low strobe instead of a chip select. A host shifts bits in on `mosi_i`, clocked by rising edges of `sck_i`, and then marks the command by pulling `stb_ni` low for exactly one SCK pulse. The level of `mosi_i` during that one strobed clock decides the command: high commits a write, low starts a read. A write carries its 32 data bits first and its 8 address bits last. A read carries only the 8 address bits. After the strobe, the host clocks 32 more pulses to collect the addressed register on `miso_o`.

Behind the link there is a small register file: a mode word and a multiplexer word that drive board settings, a reset word, and a read-only version word. Writing 1 to the reset word produces a fixed-width, active-low system-reset pulse. The reset word then clears itself. All link inputs are synchronised into the faster `clk_i` domain, and every edge is detected there.

Top module: `strobe_reg_slave`

## Requirements
- R1: After `rst_ni` is released, `miso_o` is 0, `sys_rst_no` is 1, and `mode_o` and `mux_o` are 0.
- R2: A write takes the 8 bits shifted most recently before the strobed clock as the address and the 32 bits shifted before those as the data, both MSB first. Any bits shifted earlier have no effect.
- R3: During the strobed clock, `mosi_i` = 1 selects a write and `mosi_i` = 0 selects a read. A read changes no register.
- R4: After the strobe returns high on a read, bit 31 of the addressed register is on `miso_o` before the next SCK rising edge. Each following SCK falling edge moves the next lower bit onto `miso_o`.
- R5: Address 0x00 holds the mode word and address 0x02 holds the multiplexer word; both are read/write. Address 0x80 holds the reset word (read/write). Address 0xFF reads the `VERSION` parameter.
- R6: A read of any other address returns 0. A write to any other address, or to 0xFF, changes nothing.
- R7: Writing exactly 1 to address 0x80 drives `sys_rst_no` low for `PULSE_W` (default 16) consecutive `clk_i` cycles. Any other value written there is stored and produces no pulse. A write of 1 while a pulse is active does not extend that pulse.
- R8: When the pulse ends, the reset word reads back 0.
- R9: A read of 0xFF straight after reset returns `VERSION` and leaves `mode_o`, `mux_o`, `sys_rst_no` and the reset word unchanged.
- R10: `mode_o` and `mux_o` always show the current mode and multiplexer words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the SCK rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host, idles low |
| mosi_i | input | 1 | Serial data from the host |
| stb_ni | input | 1 | Active-low command strobe, one SCK pulse long |
| miso_o | output | 1 | Serial read data to the host |
| sys_rst_no | output | 1 | Active-low system-reset pulse |
| mode_o | output | 32 | Current mode word |
| mux_o | output | 32 | Current multiplexer word |

## Verification
Each input passes two synchroniser flops and one edge flop, and command decode adds one more register. A write therefore reaches `mode_o` or `mux_o` about five `clk_i` cycles after the strobed SCK rising edge. The bench checks those outputs 12 cycles after the strobe returns high.

The reset pulse starts one cycle after the decoded command. A monitor in the bench samples `sys_rst_no` at every falling clock edge and records the length of each low run. The pulse width is checked once the write frame and 30 idle cycles have passed.

Read data is loaded about four cycles after the strobe returns high, and the bench waits 8 cycles before the first data pulse. Each read bit is sampled halfway through the SCK-high phase, at least six cycles after the falling edge that shifted it.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_MODE = 8'h00;
  localparam logic [ADDR_W-1:0] A_MUX  = 8'h02;
  localparam logic [ADDR_W-1:0] A_RST  = 8'h80;
  localparam logic [ADDR_W-1:0] A_VER  = 8'hFF;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= RST_VAL;
        else         pipe_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= RST_VAL;
        else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/srs_frame.sv
module srs_frame import srs_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_s_i,
  input  logic              stb_s_i,
  input  logic              mosi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              cmd_valid_o,
  output logic              cmd_write_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              miso_o
);
  localparam int FRAME_W = DATA_W + ADDR_W;

  logic               sck_d_q, stb_d_q;
  logic [FRAME_W-1:0] shift_q;
  logic               rd_pend_q;
  logic [DATA_W-1:0]  out_q;
  logic               sck_rise, sck_fall, stb_rise;

  assign sck_rise = sck_s_i & ~sck_d_q;
  assign sck_fall = ~sck_s_i & sck_d_q;
  assign stb_rise = stb_s_i & ~stb_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q     <= 1'b0;
      stb_d_q     <= 1'b1;
      shift_q     <= '0;
      cmd_valid_o <= 1'b0;
      cmd_write_o <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
      rd_pend_q   <= 1'b0;
      out_q       <= '0;
    end else begin
      sck_d_q     <= sck_s_i;
      stb_d_q     <= stb_s_i;
      cmd_valid_o <= 1'b0;
      if (sck_rise) begin
        if (stb_s_i) begin
          shift_q <= {shift_q[FRAME_W-2:0], mosi_s_i};
        end else begin
          // strobed clock: commit, mosi level picks direction
          cmd_valid_o <= 1'b1;
          cmd_write_o <= mosi_s_i;
          cmd_addr_o  <= shift_q[ADDR_W-1:0];
          cmd_data_o  <= shift_q[FRAME_W-1:ADDR_W];
          rd_pend_q   <= ~mosi_s_i;
        end
      end
      if (stb_rise && rd_pend_q) begin
        out_q     <= rd_data_i;
        rd_pend_q <= 1'b0;
      end else if (sck_fall) begin
        out_q <= {out_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o = out_q[DATA_W-1];
endmodule

// File: rtl/srs_pulse.sv
module srs_pulse #(
  parameter int PULSE_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_W);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/srs_regs.sv
module srs_regs import srs_pkg::*; #(
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0203
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              pulse_busy_i,
  input  logic              pulse_done_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mux_o,
  output logic [DATA_W-1:0] rst_val_o,
  output logic              pulse_start_o
);
  logic wr;
  assign wr = cmd_valid_i & cmd_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      mux_o  <= '0;
    end else if (wr) begin
      if (cmd_addr_i == A_MODE) mode_o <= cmd_data_i;
      if (cmd_addr_i == A_MUX)  mux_o  <= cmd_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          rst_val_o <= '0;
    else if (wr && cmd_addr_i == A_RST)   rst_val_o <= cmd_data_i;
    else if (pulse_done_i)                rst_val_o <= '0;

  // no retrigger while a pulse is running
  assign pulse_start_o = wr && (cmd_addr_i == A_RST) &&
                         (cmd_data_i == DATA_W'(1)) && !pulse_busy_i;

  always_comb begin
    unique case (cmd_addr_i)
      A_MODE:  rd_data_o = mode_o;
      A_MUX:   rd_data_o = mux_o;
      A_RST:   rd_data_o = rst_val_o;
      A_VER:   rd_data_o = VERSION;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave import srs_pkg::*; #(
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0203,
  parameter int PULSE_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              stb_ni,
  output logic              miso_o,
  output logic              sys_rst_no,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mux_o
);
  logic [2:0]        sync_q;
  logic              cmd_valid, cmd_write;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data, rd_data, rst_val;
  logic              pulse_start, pulse_busy, pulse_done;

  srs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({stb_ni, mosi_i, sck_i}),
    .q_o   (sync_q)
  );

  srs_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_s_i    (sync_q[0]),
    .stb_s_i    (sync_q[2]),
    .mosi_s_i   (sync_q[1]),
    .rd_data_i  (rd_data),
    .cmd_valid_o(cmd_valid),
    .cmd_write_o(cmd_write),
    .cmd_addr_o (cmd_addr),
    .cmd_data_o (cmd_data),
    .miso_o     (miso_o)
  );

  srs_regs #(.VERSION(VERSION)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid),
    .cmd_write_i  (cmd_write),
    .cmd_addr_i   (cmd_addr),
    .cmd_data_i   (cmd_data),
    .pulse_busy_i (pulse_busy),
    .pulse_done_i (pulse_done),
    .rd_data_o    (rd_data),
    .mode_o       (mode_o),
    .mux_o        (mux_o),
    .rst_val_o    (rst_val),
    .pulse_start_o(pulse_start)
  );

  srs_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(pulse_start),
    .busy_o (pulse_busy),
    .done_o (pulse_done)
  );

  assign sys_rst_no = ~pulse_busy;
endmodule

// File: rtl/srs_checker.sv
module srs_checker import srs_pkg::*; #(
  parameter int PULSE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sys_rst_no,
  input logic [DATA_W-1:0] mode_o,
  input logic [DATA_W-1:0] mux_o,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic [DATA_W-1:0] rst_val
);
  logic [31:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          low_cnt_q <= '0;
    else if (!sys_rst_no) low_cnt_q <= low_cnt_q + 1;
    else                  low_cnt_q <= '0;

  p_pulse_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> low_cnt_q == 32'(PULSE_W));

  p_pulse_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_no) |-> $past(cmd_valid && cmd_write && cmd_addr == A_RST
                                && cmd_data == DATA_W'(1)));

  p_rst_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> rst_val == '0);

  p_read_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid && !cmd_write) |=> $stable(mode_o) && $stable(mux_o));

  p_mode_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid && cmd_write && cmd_addr == A_MODE) |=> $stable(mode_o));

  p_mux_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid && cmd_write && cmd_addr == A_MUX) |=> $stable(mux_o));
endmodule

bind strobe_reg_slave srs_checker #(.PULSE_W(PULSE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sys_rst_no(sys_rst_no),
  .mode_o    (mode_o),
  .mux_o     (mux_o),
  .cmd_valid (cmd_valid),
  .cmd_write (cmd_write),
  .cmd_addr  (cmd_addr),
  .cmd_data  (cmd_data),
  .rst_val   (rst_val)
);

// File: tb/sim_strobe_reg_slave.sv
`timescale 1ns/1ps
module sim_strobe_reg_slave;
  localparam logic [31:0] VER = 32'h0001_0203;
  localparam int PW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, stb_n = 1'b1;
  logic miso, sys_rst_n;
  logic [31:0] mode, mux;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] mode_m = '0, mux_m = '0, rst_m = '0;
  int run = 0, last_w = 0, pulses = 0, pulses_exp = 0;

  always #2 clk = ~clk;

  strobe_reg_slave #(.VERSION(VER), .PULSE_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .stb_ni(stb_n),
    .miso_o(miso), .sys_rst_no(sys_rst_n), .mode_o(mode), .mux_o(mux)
  );

  always @(negedge clk) begin
    if (rst_n && !sys_rst_n) run++;
    else if (run != 0) begin last_w = run; pulses++; run = 0; end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return mode_m;
      8'h02: return mux_m;
      8'h80: return rst_m;
      8'hFF: return VER;
      default: return 32'h0;
    endcase
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    mosi = b; idle(4);
    sck = 1'b1; idle(4);
    sck = 1'b0;
  endtask

  task automatic strobe(logic wr);
    mosi = wr; stb_n = 1'b0; idle(4);
    sck = 1'b1; idle(4);
    sck = 1'b0; idle(4);
    stb_n = 1'b1; mosi = 1'b0;
  endtask

  task automatic write_frame(logic [31:0] d, logic [7:0] a);
    for (int i = 31; i >= 0; i--) send_bit(d[i]);
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
    strobe(1'b1);
    idle(12);
    case (a)
      8'h00: mode_m = d;
      8'h02: mux_m = d;
      8'h80: begin rst_m = d; if (d == 32'h1) begin pulses_exp++; rst_m = 0; end end
      default: ;
    endcase
  endtask

  task automatic read_frame(logic [7:0] a, output logic [31:0] d);
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
    strobe(1'b0);
    idle(8);
    for (int i = 31; i >= 0; i--) begin
      sck = 1'b1; idle(2);
      d[i] = miso; idle(2);
      sck = 1'b0; idle(4);
    end
    idle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0] a;
    logic [31:0] d;
    void'($urandom(32'd4242));
    idle(5); rst_n = 1'b1; idle(5);

    // R1 reset state
    check("R1 miso", {31'b0, miso}, 32'h0);
    check("R1 sys_rst_no", {31'b0, sys_rst_n}, 32'h1);
    check("R1 mode", mode, 32'h0);
    check("R1 mux", mux, 32'h0);

    // R9 dummy version read right after reset
    read_frame(8'hFF, rd);
    check("R9 version", rd, VER);
    check("R9 mode", mode, 32'h0);
    check("R9 mux", mux, 32'h0);
    check("R9 no pulse", pulses, 0);
    read_frame(8'h80, rd);
    check("R9 rst word", rd, 32'h0);

    // R2 R5 R10 write with leading junk bits
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    write_frame(32'hA5C3_0F81, 8'h00);
    check("R2 mode_o", mode, 32'hA5C3_0F81);
    write_frame(32'h8000_0001, 8'h02);
    check("R10 mux_o", mux, 32'h8000_0001);
    read_frame(8'h00, rd);
    check("R4 mode MSB first", rd, 32'hA5C3_0F81);
    read_frame(8'h02, rd);
    check("R5 mux read", rd, 32'h8000_0001);

    // R3 read leaves registers unchanged
    check("R3 mode after read", mode, 32'hA5C3_0F81);

    // R6 ignored writes
    write_frame(32'hDEAD_BEEF, 8'hFF);
    read_frame(8'hFF, rd);
    check("R6 version ro", rd, VER);
    write_frame(32'h1234_5678, 8'h01);
    read_frame(8'h01, rd);
    check("R6 unmapped read", rd, 32'h0);
    check("R6 mode kept", mode, 32'hA5C3_0F81);
    check("R6 mux kept", mux, 32'h8000_0001);

    // R7 non-one value stored, no pulse
    write_frame(32'h0000_0005, 8'h80);
    idle(30);
    check("R7 no pulse for 5", pulses, pulses_exp);
    read_frame(8'h80, rd);
    check("R7 stored 5", rd, 32'h5);

    // R7 R8 reset pulse
    write_frame(32'h0000_0001, 8'h80);
    idle(30);
    check("R7 pulse count", pulses, pulses_exp);
    check("R7 pulse width", last_w, PW);
    read_frame(8'h80, rd);
    check("R8 rst word cleared", rd, 32'h0);

    // random traffic
    for (int n = 0; n < 60; n++) begin
      case ($urandom % 6)
        0: a = 8'h00;
        1: a = 8'h02;
        2: a = 8'h80;
        3: a = 8'hFF;
        default: a = 8'($urandom);
      endcase
      if ($urandom % 2) begin
        d = $urandom;
        if (a == 8'h80 && d == 32'h1) d = 32'h2;
        write_frame(d, a);
        check("R10 mode_o", mode, mode_m);
        check("R10 mux_o", mux, mux_m);
      end else begin
        read_frame(a, rd);
        check("R5 R6 read", rd, exp_read(a));
      end
    end
    idle(30);
    check("R7 total pulses", pulses, pulses_exp);

    finished = 1;
    summary();
  end
endmodule